// File: doc/BRIEF.md
# Summed-Register Approximate Gaussian Source

The block produces one integer sample per clock whose distribution is roughly normal. Twelve 32-bit shift registers each step with right-shift Galois feedback. Each register starts from its own seed. On every step the twelve register values are added together. By the central-limit argument, the sum of many independent uniform values clusters around its mean in a bell shape. The addition runs through a registered reduction tree, so the output keeps pace with the registers at one sample per clock.

A controller writes twelve seeds with a single load strobe and then holds the enable high for as long as samples are wanted. Each output sample has a valid flag that marks whether it came from a real register step. Two forms of the sum are provided. One is the raw unsigned value. The other is a signed value that has a fixed offset removed, so that it centres near zero. The output is integer only; no scaling to floating point takes place.

Top module: `gauss_lfsr_sum`

## Requirements
- R1: While `seed_load` is high at a clock edge, every register i takes seed i from `seeds_in` bits [32*i+31:32*i]. This holds even when `enable` is also high, and no sample is marked valid for that edge.
- R2: At an edge with `enable` high and `seed_load` low, each register steps as follows. It records its bit 0, shifts right by one with a zero entering bit 31, and XORs the result with 32'h80400002 when the recorded bit was 1. The new value is the register's output for that step.
- R3: At an edge with both `enable` and `seed_load` low, the registers keep their values and the matching output slot has `sample_valid` low. The next enabled step continues the sequence from the held values.
- R4: A seed of zero is replaced on load by the nonzero default 32'h00000001, so no register ever holds zero.
- R5: `sample_sum` is the 36-bit unsigned sum of the twelve register values produced by one step. It never wraps, even with all registers at their maximum value.
- R6: A step taken at clock edge k appears on the outputs with `sample_valid` high just after edge k+4. Under a continuous enable, a new valid sample appears after every edge.
- R7: `sample_centred` equals `sample_sum` minus 6*2^32, as a 36-bit two's-complement value.
- R8: A synchronous reset (`rst` high) clears `sample_valid` and `sample_sum` and puts every register at the default 32'h00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load all registers from `seeds_in` |
| seeds_in | input | 384 | Twelve packed 32-bit seeds; seed i at bits [32*i+31:32*i] |
| enable | input | 1 | Step all registers this cycle |
| sample_sum | output | 36 | Registered unsigned sum of the twelve register values |
| sample_centred | output | 36 | Signed sum with 6*2^32 removed |
| sample_valid | output | 1 | Output slot holds a sample from a real step |

## Verification
Two situations are hard to reach from the ports. The first is a register loaded with zero, which would lock if the substitute seed were missing. The second is a sum near its ceiling, where a narrow adder would wrap. The stimulus loads zero into alternate lanes and then steps them. It also loads all-ones seeds, whose first step leaves every lane near its maximum. Enable patterns that switch on and off expose valid flags arriving out of step with their sums. A sweep of dozens of seed sets, each followed by a long stepped run, is then checked against an arithmetic model held in the bench.

// File: rtl/gauss_sum_pkg.sv
package gauss_sum_pkg;

  localparam int unsigned DEF_LANES = 12;
  localparam int unsigned DEF_LANE_W = 32;
  localparam logic [31:0] DEF_TAPS = 32'h8040_0002;
  localparam logic [31:0] DEF_SEED = 32'h0000_0001;

  // number of nodes at reduction level lvl for n leaves (ceil(n / 2^lvl))
  function automatic int unsigned level_count(input int unsigned n, input int unsigned lvl);
    level_count = (n + (1 << lvl) - 1) >> lvl;
  endfunction

endpackage

// File: rtl/gauss_lfsr_lane.sv
module gauss_lfsr_lane #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] TAPS = 32'h8040_0002,
  parameter logic [W-1:0] DEF_SEED = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state_o
);

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    lfsr_next = (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  function automatic logic [W-1:0] seed_fix(input logic [W-1:0] s);
    seed_fix = (s == '0) ? DEF_SEED : s;
  endfunction

  logic [W-1:0] state_q;
  logic         zero_seed_seen;

  assign zero_seed_seen = load && (seed == '0);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= DEF_SEED;
    else if (load) state_q <= seed_fix(seed);
    else if (step) state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;

  // R1
  load_takes_seed_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> state_q == seed_fix($past(seed)));

  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(state_q));

  // R4
  no_zero_state_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R4
  zero_seed_subst_chk: assert property (@(posedge clk) disable iff (rst)
    zero_seed_seen |=> state_q == DEF_SEED);

endmodule

// File: rtl/gauss_sum_tree.sv
module gauss_sum_tree
  import gauss_sum_pkg::*;
#(
  parameter int unsigned N = 12,
  parameter int unsigned IN_W = 32,
  parameter int unsigned OUT_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N*IN_W-1:0] in_flat,
  input  logic              v_in,
  output logic [OUT_W-1:0]  sum_o,
  output logic              v_o
);

  localparam int unsigned LEVELS = $clog2(N);
  localparam logic [OUT_W-1:0] LEAF_MAX = OUT_W'({IN_W{1'b1}});
  localparam logic [OUT_W-1:0] MAX_SUM = OUT_W'(N) * LEAF_MAX;

  for (genvar l = 0; l <= LEVELS; l++) begin : lv
    localparam int unsigned CNT = level_count(N, l);
    logic [OUT_W-1:0] node [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_j
        assign node[j] = OUT_W'(in_flat[j*IN_W +: IN_W]);
      end
    end else begin : g_add
      localparam int unsigned PREV = level_count(N, l - 1);
      for (genvar j = 0; j < CNT; j++) begin : g_j
        if (2*j + 1 < PREV) begin : g_pair
          always_ff @(posedge clk) begin
            if (rst) node[j] <= '0;
            else     node[j] <= lv[l-1].node[2*j] + lv[l-1].node[2*j+1];
          end
        end else begin : g_pass
          always_ff @(posedge clk) begin
            if (rst) node[j] <= '0;
            else     node[j] <= lv[l-1].node[2*j];
          end
        end
      end
    end
  end

  logic [LEVELS-1:0] vpipe;
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LEVELS-2:0], v_in};
  end

  assign sum_o = lv[LEVELS].node[0];
  assign v_o   = vpipe[LEVELS-1];

  // warm-up counter so the valid check never looks before reset
  logic [$clog2(LEVELS+1):0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q < ($clog2(LEVELS+1)+1)'(LEVELS)) warm_q <= warm_q + 1'b1;
  end

  // R6
  valid_align_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == ($clog2(LEVELS+1)+1)'(LEVELS)) |-> (v_o == $past(v_in, LEVELS)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (sum_o <= MAX_SUM));

endmodule

// File: rtl/gauss_lfsr_sum.sv
module gauss_lfsr_sum
  import gauss_sum_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter logic [LANE_W-1:0] TAPS = DEF_TAPS,
  parameter logic [LANE_W-1:0] DEF_SEED_VAL = DEF_SEED,
  parameter bit CENTRE_EN = 1'b1,
  localparam int unsigned SUM_W = LANE_W + $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      seed_load,
  input  logic [NUM_SRC*LANE_W-1:0] seeds_in,
  input  logic                      enable,
  output logic [SUM_W-1:0]          sample_sum,
  output logic [SUM_W-1:0]          sample_centred,
  output logic                      sample_valid
);

  localparam logic [SUM_W-1:0] OFFSET = SUM_W'(NUM_SRC / 2) << LANE_W;

  logic                      step_fire;
  logic                      step_q;
  logic [NUM_SRC*LANE_W-1:0] lane_bus;

  assign step_fire = enable && !seed_load;

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= step_fire;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    gauss_lfsr_lane #(
      .W(LANE_W), .TAPS(TAPS), .DEF_SEED(DEF_SEED_VAL)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load   (seed_load),
      .step   (step_fire),
      .seed   (seeds_in[i*LANE_W +: LANE_W]),
      .state_o(lane_bus[i*LANE_W +: LANE_W])
    );
  end

  gauss_sum_tree #(
    .N(NUM_SRC), .IN_W(LANE_W), .OUT_W(SUM_W)
  ) u_tree (
    .clk    (clk),
    .rst    (rst),
    .in_flat(lane_bus),
    .v_in   (step_q),
    .sum_o  (sample_sum),
    .v_o    (sample_valid)
  );

  if (CENTRE_EN) begin : g_centre
    assign sample_centred = sample_sum - OFFSET;
  end else begin : g_nocentre
    assign sample_centred = '0;
  end

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sample_valid && sample_sum == '0));

endmodule

// File: tb/tb_gauss_lfsr_sum.sv
module tb_gauss_lfsr_sum;

  localparam int L = 12;
  localparam int W = 32;
  localparam int SW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_load = 1'b0;
  logic enable = 1'b0;
  logic [L*W-1:0] seeds_in = '0;
  logic [SW-1:0] sample_sum, sample_centred;
  logic sample_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R8";

  logic [W-1:0] m [L];
  logic hv [5];
  logic [SW-1:0] hs [5];

  always #4 clk = ~clk;

  gauss_lfsr_sum dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seeds_in(seeds_in),
    .enable(enable), .sample_sum(sample_sum),
    .sample_centred(sample_centred), .sample_valid(sample_valid)
  );

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = {1'b0, s[W-1:1]};
    if (s[0]) t = t ^ 32'h8040_0002;
    return t;
  endfunction

  function automatic logic [SW-1:0] model_sum();
    logic [SW-1:0] acc = '0;
    for (int j = 0; j < L; j++) acc = acc + {4'b0, m[j]};
    return acc;
  endfunction

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic ld, input logic en);
    logic [SW-1:0] offs;
    seed_load = ld;
    enable = en;
    @(posedge clk);
    if (rst) begin
      for (int j = 0; j < L; j++) m[j] = 32'h1;
      for (int k = 0; k < 5; k++) begin hv[k] = 1'b0; hs[k] = '0; end
    end else begin
      if (ld) begin
        for (int j = 0; j < L; j++) begin
          m[j] = seeds_in[j*W +: W];
          if (m[j] == '0) m[j] = 32'h1;
        end
      end else if (en) begin
        for (int j = 0; j < L; j++) m[j] = ref_step(m[j]);
      end
      for (int k = 4; k > 0; k--) begin hv[k] = hv[k-1]; hs[k] = hs[k-1]; end
      hv[0] = en && !ld;
      hs[0] = model_sum();
    end
    @(negedge clk);
    offs = 36'd6 << 32;
    if (rst) begin
      check("R8 valid", {35'b0, sample_valid}, '0);
      check("R8 sum", sample_sum, '0);
    end else begin
      check({"R6 valid/", tag}, {35'b0, sample_valid}, {35'b0, hv[4]});
      if (hv[4]) begin
        check({"R5 sum/", tag}, sample_sum, hs[4]);
        check({"R7 centred/", tag}, sample_centred, hs[4] - offs);
      end
    end
  endtask

  task automatic set_seeds(input int k, input bit zero_even, input bit all_ones);
    for (int j = 0; j < L; j++) begin
      logic [W-1:0] s;
      s = (32'h9E37_79B9 * (k * L + j + 1)) ^ (32'(k) << j);
      if (all_ones) s = '1;
      if (zero_even && (j % 2 == 0)) s = '0;
      seeds_in[j*W +: W] = s;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8: reset state
    for (int c = 0; c < 3; c++) tick(1'b0, 1'b1);
    rst = 1'b0;
    // R8 lanes start from default; R2 stepping, R6 latency
    tag = "R2";
    for (int c = 0; c < 20; c++) tick(1'b0, 1'b1);
    // R1: load wins over enable
    tag = "R1";
    set_seeds(1, 1'b0, 1'b0);
    tick(1'b1, 1'b1);
    for (int c = 0; c < 10; c++) tick(1'b0, 1'b1);
    // R3: holds when enable is low
    tag = "R3";
    for (int c = 0; c < 45; c++) tick(1'b0, (c % 3) != 0);
    // R4: zero seeds substituted
    tag = "R4";
    set_seeds(2, 1'b1, 1'b0);
    tick(1'b1, 1'b0);
    for (int c = 0; c < 30; c++) tick(1'b0, 1'b1);
    // R5: all-ones seeds, sum near ceiling
    tag = "R5";
    set_seeds(0, 1'b0, 1'b1);
    tick(1'b1, 1'b0);
    for (int c = 0; c < 10; c++) tick(1'b0, 1'b1);
    // sweep of seed sets
    tag = "R2";
    for (int k = 3; k < 43; k++) begin
      set_seeds(k, (k % 5) == 0, 1'b0);
      tick(1'b1, k[0]);
      for (int c = 0; c < 50; c++) tick(1'b0, (c % 7) != 6);
    end
    // R6: drain, valid falls
    tag = "R6";
    for (int c = 0; c < 8; c++) tick(1'b0, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule